// File: doc/BRIEF.md
# Monochrome Bitmap Pixel Fetcher

This block sits between a display timing generator and a one-bit-per-pixel video RAM. For every scan position it receives (a column counter and a row counter), it works out which byte of the frame buffer holds that pixel and sends that byte address to the RAM read port. One clock later, when the RAM returns the byte, it picks out the pixel's bit and drives either full white or black, with a flag that marks whether the position lies in the visible area.

The frame buffer is 8192 bytes and holds a logical image of 256 by 256 pixels. Each image row uses 32 consecutive bytes, and row n+1 starts right after row n. Inside a byte the leftmost pixel sits in the least significant bit. Only a window of 200 columns by 150 rows, anchored at the top-left corner of the image, reaches the screen. Every other scan position reads nothing and shows black. The image size, window size, counter widths, output intensity width and bit order are all parameters.

Top module: `mono_pixel_fetch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pix_valid` is 0 and `pix_val` is 0, whatever the scan position and RAM data.
- R2: For a position with column < 200 and row < 150, `vram_rd_en` is 1 and `vram_addr` equals row*32 + floor(column/8) in the same cycle the position is presented.
- R3: For a position outside the visible window, `vram_rd_en` is 0 and `vram_addr` is 0 in the same cycle.
- R4: Pixel column c uses bit (c mod 8) of its byte, so bit 0 is the leftmost pixel of the byte and bit 7 the rightmost.
- R5: A set bit gives `pix_val` = 255 (all ones) and a clear bit gives 0. No other value appears.
- R6: `pix_valid` is 1 exactly one clock after a visible position is presented, and 0 one clock after a non-visible one.
- R7: One clock after a non-visible position, `pix_val` is 0 even when the RAM data bus holds 8'hFF.
- R8: Column 199 and row 149 are visible. Column 200 and row 150 are not.
- R9: Positions presented on consecutive clocks each produce their own pixel exactly one clock later, with no gap and no repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_col | input | 10 | Current column from the timing generator |
| scan_row | input | 10 | Current row from the timing generator |
| vram_rd_en | output | 1 | Read strobe to the video RAM, high for visible positions |
| vram_addr | output | 13 | Byte address to the video RAM |
| vram_rdata | input | 8 | Byte returned by the RAM one clock after the read |
| pix_val | output | 8 | Pixel intensity, 0 or 255 |
| pix_valid | output | 1 | High when `pix_val` belongs to the visible window |

## Verification
The address and read strobe respond combinationally, so the bench checks them shortly after it drives a position on the falling edge, before the next rising edge. The pixel and its valid flag are due one rising edge later, once the bench's RAM model has registered its byte. The bench samples them two nanoseconds after that edge and compares them against the position driven one cycle earlier. Positions are driven on back-to-back cycles, so any extra or missing pipeline stage appears as a mismatch against the neighbouring pixel.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   localparam int BYTE_BITS = 8;
   localparam int BIT_IDX_W = 3;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int clog2_min1(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/mpf_scan_decode.sv
module mpf_scan_decode #(
   parameter int COL_W   = 10,
   parameter int ROW_W   = 10,
   parameter int IMG_W   = 256,
   parameter int IMG_H   = 256,
   parameter int VIS_W   = 200,
   parameter int VIS_H   = 150,
   parameter int ADDR_W  = 13
) (
   input  logic [COL_W-1:0]                scan_col,
   input  logic [ROW_W-1:0]                scan_row,
   output logic                            in_win,
   output logic [ADDR_W-1:0]               byte_addr,
   output logic [mpf_pkg::BIT_IDX_W-1:0]   bit_idx
);
   import mpf_pkg::*;

   localparam int BYTES_PER_ROW = IMG_W / BYTE_BITS;
   localparam int ROW_SHIFT     = clog2_min1(BYTES_PER_ROW);
   localparam int BCOL_W        = COL_W - BIT_IDX_W;

   logic              col_ok;
   logic              row_ok;
   logic [BCOL_W-1:0] byte_col;
   logic [ADDR_W-1:0] raw_addr;

   assign col_ok   = ({1'b0, scan_col} < (COL_W+1)'(VIS_W));
   assign row_ok   = ({1'b0, scan_row} < (ROW_W+1)'(VIS_H));
   assign in_win   = col_ok & row_ok;
   assign byte_col = scan_col[COL_W-1:BIT_IDX_W];
   assign bit_idx  = scan_col[BIT_IDX_W-1:0];

   generate
      if (is_pow2(BYTES_PER_ROW)) begin : g_shift_addr
         logic [ADDR_W+ROW_W+COL_W-1:0] wide;
         assign wide     = ({{(ADDR_W+COL_W){1'b0}}, scan_row} << ROW_SHIFT)
                         + {{(ADDR_W+ROW_W+BIT_IDX_W){1'b0}}, byte_col};
         assign raw_addr = wide[ADDR_W-1:0];
      end else begin : g_mult_addr
         logic [ADDR_W+ROW_W+COL_W-1:0] wide;
         assign wide     = ({{(ADDR_W+COL_W){1'b0}}, scan_row}
                            * (ADDR_W+ROW_W+COL_W)'(BYTES_PER_ROW))
                         + {{(ADDR_W+ROW_W+BIT_IDX_W){1'b0}}, byte_col};
         assign raw_addr = wide[ADDR_W-1:0];
      end
   endgenerate

   assign byte_addr = in_win ? raw_addr : '0;

endmodule

// File: rtl/mpf_align_pipe.sv
module mpf_align_pipe #(
   parameter int LATENCY = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            vis_in,
   input  logic [mpf_pkg::BIT_IDX_W-1:0]   bit_in,
   output logic                            vis_out,
   output logic [mpf_pkg::BIT_IDX_W-1:0]   bit_out
);
   import mpf_pkg::*;

   logic [LATENCY-1:0]               vis_sr;
   logic [LATENCY-1:0][BIT_IDX_W-1:0] bit_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis_sr[0] <= 1'b0;
         bit_sr[0] <= '0;
      end else begin
         vis_sr[0] <= vis_in;
         bit_sr[0] <= bit_in;
      end
   end

   generate
      for (genvar s = 1; s < LATENCY; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vis_sr[s] <= 1'b0;
               bit_sr[s] <= '0;
            end else begin
               vis_sr[s] <= vis_sr[s-1];
               bit_sr[s] <= bit_sr[s-1];
            end
         end
      end
   endgenerate

   assign vis_out = vis_sr[LATENCY-1];
   assign bit_out = bit_sr[LATENCY-1];

endmodule

// File: rtl/mpf_pixel_mux.sv
module mpf_pixel_mux #(
   parameter int INTENSITY_W = 8,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic [mpf_pkg::BYTE_BITS-1:0]   byte_in,
   input  logic [mpf_pkg::BIT_IDX_W-1:0]   bit_sel,
   input  logic                            vis,
   output logic [INTENSITY_W-1:0]          pix,
   output logic                            pix_ok
);
   import mpf_pkg::*;

   logic [BIT_IDX_W-1:0] phys_idx;
   logic                 lit;

   generate
      if (LSB_FIRST) begin : g_lsb_left
         assign phys_idx = bit_sel;
      end else begin : g_msb_left
         assign phys_idx = BIT_IDX_W'(BYTE_BITS - 1) - bit_sel;
      end
   endgenerate

   assign lit    = byte_in[phys_idx] & vis;
   assign pix    = {INTENSITY_W{lit}};
   assign pix_ok = vis;

endmodule

// File: rtl/mono_pixel_fetch.sv
module mono_pixel_fetch #(
   parameter int COL_W       = 10,
   parameter int ROW_W       = 10,
   parameter int IMG_W       = 256,
   parameter int IMG_H       = 256,
   parameter int VIS_W       = 200,
   parameter int VIS_H       = 150,
   parameter int INTENSITY_W = 8,
   parameter int RAM_LAT     = 1,
   parameter bit LSB_FIRST   = 1'b1,
   localparam int ADDR_W     = $clog2(IMG_W * IMG_H / mpf_pkg::BYTE_BITS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [COL_W-1:0]         scan_col,
   input  logic [ROW_W-1:0]         scan_row,
   output logic                     vram_rd_en,
   output logic [ADDR_W-1:0]        vram_addr,
   input  logic [7:0]               vram_rdata,
   output logic [INTENSITY_W-1:0]   pix_val,
   output logic                     pix_valid
);
   import mpf_pkg::*;

   generate
      if (IMG_W % BYTE_BITS != 0) begin : g_bad_w
         $error("image width must be a multiple of eight");
      end
      if (VIS_W > IMG_W || VIS_H > IMG_H) begin : g_bad_win
         $error("visible window exceeds the image");
      end
      if ((1 << COL_W) < IMG_W || (1 << ROW_W) < IMG_H) begin : g_bad_cnt
         $error("scan counters too narrow for the image");
      end
      if (RAM_LAT < 1) begin : g_bad_lat
         $error("RAM latency must be at least one clock");
      end
      if (INTENSITY_W < 1) begin : g_bad_int
         $error("intensity width must be positive");
      end
   endgenerate

   logic                 dec_win;
   logic [BIT_IDX_W-1:0] dec_bit;
   logic                 al_vis;
   logic [BIT_IDX_W-1:0] al_bit;

   mpf_scan_decode #(
      .COL_W  (COL_W),
      .ROW_W  (ROW_W),
      .IMG_W  (IMG_W),
      .IMG_H  (IMG_H),
      .VIS_W  (VIS_W),
      .VIS_H  (VIS_H),
      .ADDR_W (ADDR_W)
   ) u_decode (
      .scan_col  (scan_col),
      .scan_row  (scan_row),
      .in_win    (dec_win),
      .byte_addr (vram_addr),
      .bit_idx   (dec_bit)
   );

   assign vram_rd_en = dec_win;

   mpf_align_pipe #(
      .LATENCY (RAM_LAT)
   ) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .vis_in  (dec_win),
      .bit_in  (dec_bit),
      .vis_out (al_vis),
      .bit_out (al_bit)
   );

   mpf_pixel_mux #(
      .INTENSITY_W (INTENSITY_W),
      .LSB_FIRST   (LSB_FIRST)
   ) u_mux (
      .byte_in (vram_rdata),
      .bit_sel (al_bit),
      .vis     (al_vis),
      .pix     (pix_val),
      .pix_ok  (pix_valid)
   );

endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
   parameter int COL_W       = 10,
   parameter int ROW_W       = 10,
   parameter int VIS_H       = 150,
   parameter int IMG_W       = 256,
   parameter int INTENSITY_W = 8,
   parameter int ADDR_W      = 13
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [COL_W-1:0]       scan_col,
   input logic                   vram_rd_en,
   input logic [ADDR_W-1:0]      vram_addr,
   input logic [7:0]             vram_rdata,
   input logic [INTENSITY_W-1:0] pix_val,
   input logic                   pix_valid
);
   localparam int ADDR_LIMIT = VIS_H * (IMG_W / 8);

   AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd_en |-> (int'(vram_addr) < ADDR_LIMIT)); // R2
   AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !vram_rd_en |-> (vram_addr == '0)); // R3
   AST_TWO_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_val == '0) || (pix_val == '1)); // R5
   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd_en |=> pix_valid); // R6
   AST_BLACK_AFTER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      !vram_rd_en |=> (!pix_valid && pix_val == '0)); // R7
   AST_BIT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd_en |=> (pix_val[0] == vram_rdata[$past(scan_col[2:0])])); // R4

endmodule

bind mono_pixel_fetch mpf_checker #(
   .COL_W       (COL_W),
   .ROW_W       (ROW_W),
   .VIS_H       (VIS_H),
   .IMG_W       (IMG_W),
   .INTENSITY_W (INTENSITY_W),
   .ADDR_W      (ADDR_W)
) u_mpf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .scan_col   (scan_col),
   .vram_rd_en (vram_rd_en),
   .vram_addr  (vram_addr),
   .vram_rdata (vram_rdata),
   .pix_val    (pix_val),
   .pix_valid  (pix_valid)
);

// File: tb/mono_pixel_fetch_bench.sv
`timescale 1ns/1ps
module mono_pixel_fetch_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] scan_col = '0;
   logic [9:0] scan_row = '0;
   logic       vram_rd_en;
   logic [12:0] vram_addr;
   logic [7:0] vram_rdata = '0;
   logic [7:0] pix_val;
   logic       pix_valid;

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] mem [0:8191];

   always #4 clk = ~clk;

   mono_pixel_fetch u_mono_pixel_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_col   (scan_col),
      .scan_row   (scan_row),
      .vram_rd_en (vram_rd_en),
      .vram_addr  (vram_addr),
      .vram_rdata (vram_rdata),
      .pix_val    (pix_val),
      .pix_valid  (pix_valid)
   );

   // one-cycle synchronous read RAM model; holds data when not enabled
   always @(posedge clk) if (vram_rd_en) vram_rdata <= mem[vram_addr];

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit vis(input int c, input int r);
      return (c < 200) && (r < 150);
   endfunction

   function automatic int exp_pix(input int c, input int r);
      logic [7:0] b;
      if (!vis(c, r)) return 0;
      b = mem[r*32 + c/8];
      return b[c % 8] ? 255 : 0;
   endfunction

   // Drive a position at the falling edge, check the address side before the
   // next rising edge, then check the pixel 2 ns after that rising edge.
   task automatic step(input int c, input int r, input string req);
      @(negedge clk);
      scan_col = 10'(c);
      scan_row = 10'(r);
      #1;
      chk({req, " R2/R3 rd_en"}, int'(vram_rd_en), int'(vis(c, r)));
      chk({req, " R2/R3 addr"}, int'(vram_addr), vis(c, r) ? (r*32 + c/8) : 0);
      @(posedge clk);
      #2;
      chk({req, " R6 valid"}, int'(pix_valid), int'(vis(c, r)));
      chk({req, " R5 pixel"}, int'(pix_val), exp_pix(c, r));
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      @(negedge clk);
      scan_col = 10'd0;
      scan_row = 10'd0;
      @(posedge clk); #2;
      chk("R1 valid in reset", int'(pix_valid), 0);
      chk("R1 pixel in reset", int'(pix_val), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 valid first cycle", int'(pix_valid), 0);
      chk("R1 pixel first cycle", int'(pix_val), 0);
   endtask

   task automatic t_bit_order;
      for (int c = 0; c < 16; c++) step(c, 0, "R4 order row0");
      for (int c = 0; c < 8; c++) step(c, 1, "R4 order row1");
   endtask

   task automatic t_addr_map;
      step(17, 5, "R2 map");
      step(100, 77, "R2 map");
      step(63, 149, "R2 map");
      step(8, 31, "R2 map");
   endtask

   task automatic t_edges;
      step(199, 0, "R8 col199");
      step(200, 0, "R8 col200");
      step(0, 149, "R8 row149");
      step(0, 150, "R8 row150");
      step(199, 149, "R8 corner");
      step(255, 255, "R3 far");
      step(1023, 1023, "R3 max");
   endtask

   task automatic t_outside_black;
      step(0, 3, "R7 prime FF");
      chk("R7 bus holds FF", int'(vram_rdata), 255);
      step(250, 3, "R7 outside col");
      chk("R7 bus still FF", int'(vram_rdata), 255);
      step(0, 200, "R7 outside row");
   endtask

   task automatic t_raster;
      for (int r = 146; r < 152; r++)
         for (int c = 190; c < 206; c++) step(c, r, "R9 raster");
      for (int c = 0; c < 210; c++) step(c, 42, "R9 line");
   endtask

   initial begin
      for (int i = 0; i < 8192; i++) mem[i] = 8'(i * 37) ^ 8'(i >> 5) ^ 8'h5A;
      mem[0]  = 8'h01;
      mem[1]  = 8'hA5;
      mem[24] = 8'h80;
      mem[32] = 8'h80;
      mem[96] = 8'hFF;
      mem[149*32] = 8'h01;
      t_reset();
      t_bit_order();
      t_addr_map();
      t_edges();
      t_outside_black();
      t_raster();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule